// File: doc/BRIEF.md
# TDM Time-Slot Routing Sequencer

This block splits a serial time-division frame into slots and routes each slot to one of five channel ports. Two small tables of routing entries, one for the receive direction and one for the transmit direction, describe the frame. Each direction has its own sequencer and its own frame-start pulse. On that pulse the sequencer starts at entry 0 and spends each entry's length, counted in bits or in bytes, on the channel the entry selects. It stops after the entry flagged as last and then waits for the next pulse. The block handles one line bit per clock.

On the receive side, each routed bit is handed to its channel with a one-cycle strobe. On the transmit side, the selected channel is asked for a bit one cycle before that bit appears on the line pin, and the pin's output enable is raised only for slots that select a real channel. An entry's swap flag reverses the pin roles for its slot: it receives from the transmit pin or drives the receive pin. Two stations can then talk to each other over a shared pair of lines. The tables are filled through a simple write port.

Top module: `tdm_slot_router`

## Requirements
- R1: A write with `tbl_we` high stores `tbl_wdata` at `tbl_addr` in the receive table (`tbl_sel`=0) or the transmit table (`tbl_sel`=1). The entry layout is: bit 15 swap, bits 14:9 ignored, bits 8:6 channel code, bits 5:2 count, bit 1 byte unit, bit 0 last.
- R2: A frame-start pulse (`rx_sync` or `tx_sync`) seen at a rising edge makes that direction work on entry 0 from the next cycle. `rx_idx`/`tx_idx` show the entry in use and read 0 while idle. The two directions run independently.
- R3: An entry lasts count+1 clock cycles when its byte-unit bit is 0, and 8*(count+1) cycles when it is 1. The next entry follows directly.
- R4: Once the entry with the last bit set has completed, the direction goes idle. It then produces no strobes, requests or enables, and its index stays 0 until the next frame-start pulse.
- R5: The final table entry (index 15) ends the frame even when its last bit is clear.
- R6: A frame-start pulse that arrives while a frame is in progress restarts the walk at entry 0 in the next cycle.
- R7: For a receive slot with channel code 2 to 6, the bit on `rxd_in` during the slot cycle appears on `ch_rx_data[code-2]`. `ch_rx_valid[code-2]` is high for exactly the following cycle, and no other strobe is high.
- R8: Receive slots with channel code 0, 1 or 7, and idle cycles, raise no `ch_rx_valid` bit.
- R9: A receive slot whose swap bit is set takes its bit from `txd_in` instead of `rxd_in`.
- R10: For a transmit slot with channel code 2 to 6 and swap clear, `ch_tx_req[code-2]` is high during the slot cycle. The value of `ch_tx_data[code-2]` in that cycle is driven on `txd_out` with `txd_oe` high in the next cycle.
- R11: Transmit slots with channel code 0, 1 or 7, and idle cycles, raise no `ch_tx_req` bit. They leave `txd_oe` and `rxd_oe` low in the next cycle.
- R12: A transmit slot with swap set and channel code 2 to 6 drives the requested bit on `rxd_out` with `rxd_oe` high and `txd_oe` low in the next cycle. With swap set and an unused code, neither enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sync | input | 1 | Receive frame-start pulse |
| tx_sync | input | 1 | Transmit frame-start pulse |
| rxd_in | input | 1 | Level seen on the line receive pin |
| txd_in | input | 1 | Level seen on the line transmit pin |
| ch_tx_data | input | 5 | Transmit bit offered by each channel |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | Table select: 0 receive, 1 transmit |
| tbl_addr | input | 4 | Entry address for the write |
| tbl_wdata | input | 16 | Entry value for the write |
| ch_rx_data | output | 5 | Received bit for each channel |
| ch_rx_valid | output | 5 | One-cycle strobe per delivered bit |
| ch_tx_req | output | 5 | Channel whose bit is taken this cycle |
| txd_out | output | 1 | Value for the transmit pin |
| txd_oe | output | 1 | Transmit pin output enable |
| rxd_out | output | 1 | Value for the receive pin in swapped slots |
| rxd_oe | output | 1 | Receive pin output enable |
| rx_idx | output | 4 | Receive entry in use |
| tx_idx | output | 4 | Transmit entry in use |

## Verification
The entry indices and `ch_tx_req` are due in the slot cycle itself. Receive strobes and data, and both pin drives with their enables, are due exactly one cycle after the slot. The slot cycle starts at the first edge after the frame-start pulse is seen. The driver checks index and request a moment after it drives each slot. It queues the delayed results stamped with the cycle number they are due in, and the monitor compares each queued item only once the cycle count reaches its stamp. Idle cycles after the last entry and after a restart are queued as well, so results that are too early, too late or missing all show up as mismatches.

// File: rtl/tdm_route_pkg.sv
package tdm_route_pkg;

  localparam int ENTRY_W = 16;
  localparam int CSEL_W  = 3;
  localparam int CNT_W   = 4;
  localparam int NUM_CH  = 5;

  localparam logic [CSEL_W-1:0] CSEL_LO = 3'd2;
  localparam logic [CSEL_W-1:0] CSEL_HI = 3'd6;

  typedef struct packed {
    logic              swap;
    logic [5:0]        rsvd;
    logic [CSEL_W-1:0] csel;
    logic [CNT_W-1:0]  cnt;
    logic              byte_unit;
    logic              last;
  } route_entry_t;

  typedef enum logic {WALK_IDLE = 1'b0, WALK_RUN = 1'b1} walk_state_t;

  // Channel code to one-hot port select; unused codes give zero.
  function automatic logic [NUM_CH-1:0] chan_select(logic [CSEL_W-1:0] code);
    logic [NUM_CH-1:0] sel;
    sel = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (code == CSEL_LO + CSEL_W'(c)) sel[c] = 1'b1;
    end
    return sel;
  endfunction

endpackage

// File: rtl/tdm_route_table.sv
module tdm_route_table
  import tdm_route_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         we,
  input  logic [AW-1:0] waddr,
  input  route_entry_t wdata,
  input  logic [AW-1:0] raddr,
  output route_entry_t rdata
);

  route_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/tdm_slot_walker.sv
module tdm_slot_walker
  import tdm_route_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int UNIT_BITS = 8,
  localparam int AW      = $clog2(DEPTH),
  localparam int MAX_LEN = (1 << CNT_W) * UNIT_BITS,
  localparam int POS_W   = $clog2(MAX_LEN)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sync,
  input  route_entry_t ent,
  output logic         active,
  output logic [AW-1:0] idx
);

  walk_state_t      state;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] len_m1;
  logic             at_end;
  logic             tbl_end;
  int unsigned      units;

  always_comb begin
    units  = int'(ent.cnt) + 1;
    len_m1 = ent.byte_unit ? POS_W'(units * UNIT_BITS - 1) : POS_W'(units - 1);
  end

  assign at_end  = (pos == len_m1);
  assign tbl_end = ent.last || (idx == AW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= WALK_IDLE;
      idx   <= '0;
      pos   <= '0;
    end else if (sync) begin
      state <= WALK_RUN;
      idx   <= '0;
      pos   <= '0;
    end else if (state == WALK_RUN) begin
      if (at_end) begin
        pos <= '0;
        if (tbl_end) begin
          state <= WALK_IDLE;
          idx   <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  assign active = (state == WALK_RUN);

  assert_sync_restart_R6: assert property (@(posedge clk) disable iff (rst)
    sync |=> (active && idx == '0))
    else $error("walk did not restart on sync");

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!active && !sync) |=> (!active && idx == '0))
    else $error("idle walker moved without sync");

  assert_entry_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (active && !sync && !at_end) |=> (active && idx == $past(idx)))
    else $error("entry left before its length elapsed");

  assert_table_end_R5: assert property (@(posedge clk) disable iff (rst)
    (active && !sync && at_end && idx == AW'(DEPTH - 1)) |=> !active)
    else $error("walk ran past final entry");

endmodule

// File: rtl/tdm_rx_demux.sv
module tdm_rx_demux
  import tdm_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  route_entry_t      ent,
  input  logic              rxd_in,
  input  logic              txd_in,
  output logic [NUM_CH-1:0] ch_rx_data,
  output logic [NUM_CH-1:0] ch_rx_valid
);

  logic [NUM_CH-1:0] hit;
  logic              line_bit;

  assign hit      = active ? chan_select(ent.csel) : '0;
  assign line_bit = ent.swap ? txd_in : rxd_in;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        ch_rx_valid[c] <= 1'b0;
        ch_rx_data[c]  <= 1'b0;
      end else begin
        ch_rx_valid[c] <= hit[c];
        if (hit[c]) ch_rx_data[c] <= line_bit;
      end
    end
  end

  assert_rx_single_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_rx_valid))
    else $error("more than one receive strobe");

  assert_rx_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !active |=> (ch_rx_valid == '0))
    else $error("receive strobe while idle");

endmodule

// File: rtl/tdm_tx_mux.sv
module tdm_tx_mux
  import tdm_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  route_entry_t      ent,
  input  logic [NUM_CH-1:0] ch_tx_data,
  output logic [NUM_CH-1:0] ch_tx_req,
  output logic              txd_out,
  output logic              txd_oe,
  output logic              rxd_out,
  output logic              rxd_oe
);

  logic tx_bit;
  logic used;

  assign ch_tx_req = active ? chan_select(ent.csel) : '0;
  assign used      = |ch_tx_req;
  assign tx_bit    = |(ch_tx_req & ch_tx_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      txd_out <= 1'b0;
      txd_oe  <= 1'b0;
      rxd_out <= 1'b0;
      rxd_oe  <= 1'b0;
    end else begin
      txd_oe  <= used && !ent.swap;
      rxd_oe  <= used && ent.swap;
      txd_out <= tx_bit && !ent.swap;
      rxd_out <= tx_bit && ent.swap;
    end
  end

  assert_req_single_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_tx_req))
    else $error("more than one transmit request");

  assert_req_drives_R10: assert property (@(posedge clk) disable iff (rst)
    (|ch_tx_req) |=> (txd_oe ^ rxd_oe))
    else $error("request not followed by one pin drive");

  assert_quiet_pins_R11: assert property (@(posedge clk) disable iff (rst)
    (ch_tx_req == '0) |=> (!txd_oe && !rxd_oe))
    else $error("pin enabled without a request");

endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
  import tdm_route_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int UNIT_BITS = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rx_sync,
  input  logic               tx_sync,
  input  logic               rxd_in,
  input  logic               txd_in,
  input  logic [NUM_CH-1:0]  ch_tx_data,
  input  logic               tbl_we,
  input  logic               tbl_sel,
  input  logic [AW-1:0]      tbl_addr,
  input  logic [ENTRY_W-1:0] tbl_wdata,
  output logic [NUM_CH-1:0]  ch_rx_data,
  output logic [NUM_CH-1:0]  ch_rx_valid,
  output logic [NUM_CH-1:0]  ch_tx_req,
  output logic               txd_out,
  output logic               txd_oe,
  output logic               rxd_out,
  output logic               rxd_oe,
  output logic [AW-1:0]      rx_idx,
  output logic [AW-1:0]      tx_idx
);

  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;
  localparam int N_DIR  = 2;

  logic         dir_sync   [N_DIR];
  logic         dir_active [N_DIR];
  logic [AW-1:0] dir_idx   [N_DIR];
  route_entry_t dir_ent    [N_DIR];
  route_entry_t wr_entry;

  assign wr_entry         = route_entry_t'(tbl_wdata);
  assign dir_sync[DIR_RX] = rx_sync;
  assign dir_sync[DIR_TX] = tx_sync;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    tdm_route_table #(.DEPTH(DEPTH)) u_table (
      .clk   (clk),
      .we    (tbl_we && (tbl_sel == 1'(d))),
      .waddr (tbl_addr),
      .wdata (wr_entry),
      .raddr (dir_idx[d]),
      .rdata (dir_ent[d])
    );

    tdm_slot_walker #(.DEPTH(DEPTH), .UNIT_BITS(UNIT_BITS)) u_walker (
      .clk    (clk),
      .rst    (rst),
      .sync   (dir_sync[d]),
      .ent    (dir_ent[d]),
      .active (dir_active[d]),
      .idx    (dir_idx[d])
    );
  end

  tdm_rx_demux u_rx (
    .clk         (clk),
    .rst         (rst),
    .active      (dir_active[DIR_RX]),
    .ent         (dir_ent[DIR_RX]),
    .rxd_in      (rxd_in),
    .txd_in      (txd_in),
    .ch_rx_data  (ch_rx_data),
    .ch_rx_valid (ch_rx_valid)
  );

  tdm_tx_mux u_tx (
    .clk        (clk),
    .rst        (rst),
    .active     (dir_active[DIR_TX]),
    .ent        (dir_ent[DIR_TX]),
    .ch_tx_data (ch_tx_data),
    .ch_tx_req  (ch_tx_req),
    .txd_out    (txd_out),
    .txd_oe     (txd_oe),
    .rxd_out    (rxd_out),
    .rxd_oe     (rxd_oe)
  );

  assign rx_idx = dir_idx[DIR_RX];
  assign tx_idx = dir_idx[DIR_TX];

endmodule

// File: tb/test_tdm_slot_router.sv
module test_tdm_slot_router;
  import tdm_route_pkg::*;

  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int NCH   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic rx_sync = 0, tx_sync = 0, rxd_in = 0, txd_in = 0;
  logic [NCH-1:0] ch_tx_data = '0;
  logic tbl_we = 0, tbl_sel = 0;
  logic [AW-1:0] tbl_addr = '0;
  logic [15:0] tbl_wdata = '0;
  logic [NCH-1:0] ch_rx_data, ch_rx_valid, ch_tx_req;
  logic txd_out, txd_oe, rxd_out, rxd_oe;
  logic [AW-1:0] rx_idx, tx_idx;

  tdm_slot_router i_tdm_slot_router (
    .clk(clk), .rst(rst), .rx_sync(rx_sync), .tx_sync(tx_sync),
    .rxd_in(rxd_in), .txd_in(txd_in), .ch_tx_data(ch_tx_data),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .ch_rx_data(ch_rx_data), .ch_rx_valid(ch_rx_valid), .ch_tx_req(ch_tx_req),
    .txd_out(txd_out), .txd_oe(txd_oe), .rxd_out(rxd_out), .rxd_oe(rxd_oe),
    .rx_idx(rx_idx), .tx_idx(tx_idx)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    int             due;
    logic [NCH-1:0] rv;
    logic [NCH-1:0] rd;
    logic           rsw;
    logic           tused;
    logic           tsw;
    logic           toe;
    logic           roe;
    logic           tb;
  } exp_t;

  exp_t sbq[$];
  route_entry_t rx_tab[DEPTH];
  route_entry_t tx_tab[DEPTH];
  int rsched[$];
  int tsched[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [NCH-1:0] hot(logic [2:0] cs);
    if (cs >= 3'd2 && cs <= 3'd6) return NCH'(1) << (cs - 3'd2);
    return '0;
  endfunction

  function automatic route_entry_t mk(bit sw, int cs, int cn, bit by, bit la);
    route_entry_t r;
    r = '0;
    r.swap = sw; r.csel = 3'(cs); r.cnt = 4'(cn); r.byte_unit = by; r.last = la;
    r.rsvd = 6'h2a;  // R1: ignored bits carry junk
    return r;
  endfunction

  task automatic wr(bit sel, int a, route_entry_t v);
    @(negedge clk);
    tbl_we = 1; tbl_sel = sel; tbl_addr = AW'(a); tbl_wdata = v;
    if (sel) tx_tab[a] = v; else rx_tab[a] = v;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic build_sched();
    int n;
    rsched.delete(); tsched.delete();
    for (int e = 0; e < DEPTH; e++) begin
      n = (int'(rx_tab[e].cnt) + 1) * (rx_tab[e].byte_unit ? 8 : 1);
      repeat (n) rsched.push_back(e);
      if (rx_tab[e].last) break;
    end
    for (int e = 0; e < DEPTH; e++) begin
      n = (int'(tx_tab[e].cnt) + 1) * (tx_tab[e].byte_unit ? 8 : 1);
      repeat (n) tsched.push_back(e);
      if (tx_tab[e].last) break;
    end
  endtask

  // One slot cycle: drive stimulus, check same-cycle outputs, queue next-cycle results.
  task automatic step(int re, int te, bit rs, bit ts);
    exp_t x;
    route_entry_t rent, tent;
    logic [NCH-1:0] rh, th;
    @(negedge clk);
    rx_sync = rs; tx_sync = ts;
    rxd_in = 1'($urandom); txd_in = 1'($urandom); ch_tx_data = NCH'($urandom);
    rent = (re >= 0) ? rx_tab[re] : '0;
    tent = (te >= 0) ? tx_tab[te] : '0;
    rh = (re >= 0) ? hot(rent.csel) : '0;
    th = (te >= 0) ? hot(tent.csel) : '0;
    #1;
    chk((re >= 0) ? "R2/R3 rx index" : "R4 rx idle index", 32'(rx_idx), 32'((re >= 0) ? re : 0));
    chk((te >= 0) ? "R2/R3 tx index" : "R4 tx idle index", 32'(tx_idx), 32'((te >= 0) ? te : 0));
    chk((th != '0) ? "R10 tx request" : "R11 tx request", 32'(ch_tx_req), 32'(th));
    x.due   = cyc + 1;
    x.rv    = rh;
    x.rd    = {NCH{rent.swap ? txd_in : rxd_in}};
    x.rsw   = rent.swap;
    x.tused = (th != '0);
    x.tsw   = tent.swap;
    x.toe   = (th != '0) && !tent.swap;
    x.roe   = (th != '0) && tent.swap;
    x.tb    = |(th & ch_tx_data);
    sbq.push_back(x);
  endtask

  task automatic run(int ncyc, bit rs_end, bit ts_end, bit r_on, bit t_on);
    int re, te;
    for (int c = 0; c < ncyc; c++) begin
      re = (r_on && c < rsched.size()) ? rsched[c] : -1;
      te = (t_on && c < tsched.size()) ? tsched[c] : -1;
      step(re, te, rs_end && (c == ncyc - 1), ts_end && (c == ncyc - 1));
    end
  endtask

  // Monitor: compares queued results in the cycle they are due.
  initial begin
    exp_t e;
    string tg;
    forever begin
      @(negedge clk);
      #2;
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
        e = sbq.pop_front();
        chk((e.rv == '0) ? "R8 rx strobes" : (e.rsw ? "R9 rx strobes" : "R7 rx strobes"),
            32'(ch_rx_valid), 32'(e.rv));
        if (e.rv != '0)
          chk(e.rsw ? "R9 rx data" : "R7 rx data", 32'(ch_rx_data & e.rv), 32'(e.rd & e.rv));
        tg = !e.tused ? (e.tsw ? "R12 listen-only" : "R11") : (e.tsw ? "R12" : "R10");
        chk({tg, " txd_oe"}, 32'(txd_oe), 32'(e.toe));
        chk({tg, " rxd_oe"}, 32'(rxd_oe), 32'(e.roe));
        if (e.toe) chk({tg, " txd_out"}, 32'(txd_out), 32'(e.tb));
        if (e.roe) chk({tg, " rxd_out"}, 32'(rxd_out), 32'(e.tb));
      end
    end
  end

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    #1;
    // R4/R11: reset state is idle
    chk("R4 reset rx strobes", 32'(ch_rx_valid), 0);
    chk("R11 reset enables", 32'({txd_oe, rxd_oe}), 0);
    chk("R11 reset requests", 32'(ch_tx_req), 0);
    chk("R2 reset indices", 32'({rx_idx, tx_idx}), 0);

    // Mixed table: bit and byte units, unused codes, swaps (R1, R3, R7-R12)
    wr(0, 0, mk(0, 2, 3, 0, 0));
    wr(0, 1, mk(0, 0, 1, 0, 0));
    wr(0, 2, mk(1, 4, 0, 1, 0));
    wr(0, 3, mk(0, 6, 2, 0, 0));
    wr(0, 4, mk(0, 7, 0, 0, 0));
    wr(0, 5, mk(0, 3, 0, 0, 1));
    wr(0, 6, mk(0, 5, 3, 0, 0));
    wr(1, 0, mk(0, 5, 2, 0, 0));
    wr(1, 1, mk(0, 1, 0, 0, 0));
    wr(1, 2, mk(1, 3, 1, 0, 0));
    wr(1, 3, mk(1, 0, 0, 1, 0));
    wr(1, 4, mk(0, 6, 1, 0, 1));
    wr(1, 5, mk(0, 2, 3, 0, 0));
    build_sched();
    step(-1, -1, 1, 1);
    run(24, 0, 0, 1, 1);

    // R6: restart mid-frame, then a full frame
    step(-1, -1, 1, 1);
    run(6, 1, 1, 1, 1);
    run(24, 0, 0, 1, 1);

    // R2: receive pulse alone leaves transmit idle
    step(-1, -1, 1, 0);
    run(24, 0, 0, 1, 0);

    // R5: all entries used, none flagged last
    for (int e = 0; e < DEPTH; e++) begin
      wr(0, e, mk(0, (e % 5) + 2, 0, 0, 0));
      wr(1, e, mk(e % 2, ((e + 1) % 5) + 2, 0, 0, 0));
    end
    build_sched();
    step(-1, -1, 1, 1);
    run(20, 0, 0, 1, 1);

    // R3: longest entry, 16 bytes
    wr(0, 0, mk(0, 2, 15, 1, 1));
    wr(1, 0, mk(0, 6, 15, 1, 1));
    build_sched();
    step(-1, -1, 1, 1);
    run(131, 0, 0, 1, 1);

    repeat (3) @(negedge clk);
    done = 1;
    report();
  end

endmodule